// File: doc/BRIEF.md
# Decade 1-2-5 Clock-Enable Prescaler

This block divides the system clock by a programmable ratio. It does not produce a new clock. It produces a strobe, `tick`, that is high for one cycle of the system clock once per period. Downstream logic stays on the system clock and uses `tick` as its clock enable.

The ratio is set by two fields:

- A leading stage divides by 1, 2, 5 or 10.
- Its strobe steps a chain of cascaded modulo-10 counters. The second field chooses which point of that chain drives `tick`, from the leading stage itself up to four decades further on.

The overall ratio is therefore r × 10^k, with r in {1, 2, 5, 10} and k from 0 to 4. This covers 1 to 100000 in 1-2-5 steps.

A global enable `en` pauses counting. A change of either field restarts the period, so the new ratio takes effect cleanly.

Top module: `decade_prescaler`

## Requirements
- R1: With fixed selects and `en` high, `tick` is high for exactly one cycle out of every N cycles, where N = r × 10^k. The first pulse after a restart comes on the N-th enabled cycle, counting the restart cycle as the first.
- R2: When N = 1 (`firstSel` = 0 and `decadeSel` = 0), `tick` equals `en` on every cycle outside reset.
- R3: `firstSel` encodes r as follows: 0 → 1, 1 → 2, 2 → 5, 3 → 10.
- R4: `decadeSel` values 0 to 4 give k = 0 to 4. Values 5, 6 and 7 act as 4. Moving among the values 4 to 7 is not a select change and does not restart the period.
- R5: Cycles with `en` low do not count toward the period. The pulse comes after N enabled cycles, however they are spread out.
- R6: In any cycle where `firstSel` or the effective k differs from its value in the previous cycle, all counters restart and that cycle is the first cycle of the new period. For N > 1, `tick` is low in that cycle.
- R7: While `rst` is high, `tick` is low. The first cycle after `rst` falls is the first cycle of a period.
- R8: When `en` is low, `tick` is low and the count is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Global count enable |
| firstSel | input | 2 | Leading-stage ratio code (1/2/5/10) |
| decadeSel | input | 3 | Number of decade stages after the leading stage (5 to 7 act as 4) |
| tick | output | 1 | One-cycle clock-enable strobe |

## Verification
`tick` is a combinational function of the current inputs and the registered counters. Each result is therefore due in the same cycle as the stimulus that causes it: a restart, a reset or an `en` change shows up without delay.

The bench drives inputs on the falling edge and samples `tick` one nanosecond later, before the next rising edge. It then advances its own period counter, which represents the state the design holds after that edge.

Long ratios (10000) are run to their first and second pulses. This confirms that every decade carries on its wrap cycle and on no other cycle.

// File: rtl/presc_pkg.sv
package presc_pkg;
  localparam int PRESC_DECADES    = 4;
  localparam int PRESC_DECADE_MOD = 10;
  localparam int PRESC_SEL_W      = 3;

  typedef struct packed {
    logic advance;
    logic restart;
  } presc_strobe_t;
endpackage

// File: rtl/presc_ctrl.sv
module presc_ctrl
  import presc_pkg::*;
#(
  parameter int NUM_DECADES = PRESC_DECADES,
  parameter int SEL_W       = PRESC_SEL_W,
  localparam int TAP_W      = $clog2(NUM_DECADES + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       firstSel,
  input  logic [SEL_W-1:0] decadeSel,
  output presc_strobe_t    strobe,
  output logic [3:0]       firstLimit,
  output logic [TAP_W-1:0] tapSel
);
  logic [1:0]       firstSelQ;
  logic [TAP_W-1:0] tapSelQ;

  always_comb begin
    if (int'(decadeSel) > NUM_DECADES) tapSel = TAP_W'(NUM_DECADES);
    else                               tapSel = TAP_W'(decadeSel);
    unique case (firstSel)
      2'd0:    firstLimit = 4'd0;
      2'd1:    firstLimit = 4'd1;
      2'd2:    firstLimit = 4'd4;
      default: firstLimit = 4'd9;
    endcase
  end

  always_ff @(posedge clk) begin
    firstSelQ <= firstSel;
    tapSelQ   <= tapSel;
  end

  always_comb begin
    strobe.advance = en && !rst;
    strobe.restart = !rst && ((firstSel != firstSelQ) || (tapSel != tapSelQ));
  end
endmodule

// File: rtl/presc_datapath.sv
module presc_datapath
  import presc_pkg::*;
#(
  parameter int NUM_DECADES = PRESC_DECADES,
  parameter int DECADE_MOD  = PRESC_DECADE_MOD,
  localparam int TAP_W      = $clog2(NUM_DECADES + 1),
  localparam int CNT_W      = $clog2(DECADE_MOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  presc_strobe_t    strobe,
  input  logic [3:0]       firstLimit,
  input  logic [TAP_W-1:0] tapSel,
  output logic             tick
);
  logic [3:0]             firstCnt;
  logic [3:0]             firstEff;
  logic [NUM_DECADES:0]   stageHit;

  assign firstEff    = strobe.restart ? 4'd0 : firstCnt;
  assign stageHit[0] = strobe.advance && (firstEff == firstLimit);

  always_ff @(posedge clk) begin
    if (rst)                 firstCnt <= 4'd0;
    else if (stageHit[0])    firstCnt <= 4'd0;
    else if (strobe.advance) firstCnt <= firstEff + 4'd1;
    else                     firstCnt <= firstEff;
  end

  for (genvar g = 0; g < NUM_DECADES; g++) begin : gDecade
    logic [CNT_W-1:0] decCnt;
    logic [CNT_W-1:0] decEff;
    logic             atTop;

    assign decEff          = strobe.restart ? '0 : decCnt;
    assign atTop           = (decEff == CNT_W'(DECADE_MOD - 1));
    assign stageHit[g + 1] = stageHit[g] && atTop;

    always_ff @(posedge clk) begin
      if (rst)              decCnt <= '0;
      else if (stageHit[g]) decCnt <= atTop ? '0 : decEff + CNT_W'(1);
      else                  decCnt <= decEff;
    end
  end

  assign tick = stageHit[tapSel];
endmodule

// File: rtl/decade_prescaler.sv
module decade_prescaler
  import presc_pkg::*;
#(
  parameter int NUM_DECADES = PRESC_DECADES,
  parameter int DECADE_MOD  = PRESC_DECADE_MOD,
  parameter int SEL_W       = PRESC_SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [1:0]       firstSel,
  input  logic [SEL_W-1:0] decadeSel,
  output logic             tick
);
  localparam int TAP_W = $clog2(NUM_DECADES + 1);

  presc_strobe_t    strobe;
  logic [3:0]       firstLimit;
  logic [TAP_W-1:0] tapSel;

  presc_ctrl #(.NUM_DECADES(NUM_DECADES), .SEL_W(SEL_W)) uCtrl (
    .clk(clk), .rst(rst), .en(en), .firstSel(firstSel), .decadeSel(decadeSel),
    .strobe(strobe), .firstLimit(firstLimit), .tapSel(tapSel)
  );

  presc_datapath #(.NUM_DECADES(NUM_DECADES), .DECADE_MOD(DECADE_MOD)) uPath (
    .clk(clk), .rst(rst), .strobe(strobe), .firstLimit(firstLimit),
    .tapSel(tapSel), .tick(tick)
  );
endmodule

// File: rtl/presc_checks.sv
module presc_checks #(
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             en,
  input logic [1:0]       firstSel,
  input logic [SEL_W-1:0] decadeSel,
  input logic             tick
);
  AST_RESET_QUIET: assert property (@(posedge clk) rst |-> !tick); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !en |-> !tick); // R8

  AST_UNITY_FOLLOWS_EN: assert property (@(posedge clk) disable iff (rst)
    (en && firstSel == 2'd0 && decadeSel == '0) |-> tick); // R2

  AST_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (tick && !(firstSel == 2'd0 && decadeSel == '0))
      |=> (!tick || !$stable(firstSel) || !$stable(decadeSel))); // R1

  AST_RESTART_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!$stable(firstSel) && firstSel != 2'd0) |-> !tick); // R6
endmodule

bind decade_prescaler presc_checks #(.SEL_W(SEL_W)) uChecks (
  .clk(clk), .rst(rst), .en(en), .firstSel(firstSel),
  .decadeSel(decadeSel), .tick(tick)
);

// File: tb/decade_prescaler_test.sv
`timescale 1ns/1ps
module decade_prescaler_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [1:0] firstSel = 2'd0;
  logic [2:0] decadeSel = 3'd0;
  logic       tick;

  int checks = 0;
  int errors = 0;
  int phase = 0;
  bit gapSeen = 0;
  bit finished = 0;
  logic [1:0] mFs = 2'd0;
  logic [2:0] mDs = 3'd0;

  decade_prescaler uut (
    .clk(clk), .rst(rst), .en(en), .firstSel(firstSel),
    .decadeSel(decadeSel), .tick(tick)
  );

  function automatic int clampDec(input logic [2:0] ds);
    return (ds > 3'd4) ? 4 : int'(ds);
  endfunction

  // R3 encoding and R4 clamping
  function automatic int ratioOf(input logic [1:0] fs, input logic [2:0] ds);
    int r;
    case (fs)
      2'd0: r = 1;
      2'd1: r = 2;
      2'd2: r = 5;
      default: r = 10;
    endcase
    for (int i = 0; i < clampDec(ds); i++) r = r * 10;
    return r;
  endfunction

  task automatic step(input logic r, input logic e, input logic [1:0] fs,
                      input logic [2:0] ds);
    int n;
    bit chg;
    bit expd;
    string tag;
    @(negedge clk);
    rst = r; en = e; firstSel = fs; decadeSel = ds;
    #1;
    n   = ratioOf(fs, ds);
    chg = (fs != mFs) || (clampDec(ds) != clampDec(mDs));
    if (r) begin
      expd = 1'b0; tag = "R7";
    end else begin
      if (chg) begin phase = 0; gapSeen = 0; end
      expd = e && (phase == n - 1);
      if (!e)             tag = "R8";
      else if (chg)       tag = "R6";
      else if (n == 1)    tag = "R2";
      else if (ds > 3'd4) tag = "R4";
      else if (gapSeen)   tag = "R5";
      else                tag = "R1/R3";
    end
    checks++;
    if (tick !== expd) begin
      errors++;
      $display("FAIL %s: tick=%b expected %b (ratio %0d, phase %0d, t=%0t)",
               tag, tick, expd, n, phase, $time);
    end
    if (r) begin
      phase = 0; gapSeen = 0;
    end else if (e) begin
      if (expd) begin phase = 0; gapSeen = 0; end
      else phase++;
    end else begin
      gapSeen = 1;
    end
    mFs = fs; mDs = ds;
  endtask

  task automatic run(input int cycles, input logic [1:0] fs, input logic [2:0] ds);
    for (int i = 0; i < cycles; i++) step(1'b0, 1'b1, fs, ds);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    // R7: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 2'd1, 3'd0);
    // R2: divide by one
    run(20, 2'd0, 3'd0);
    // R3: each leading ratio, then one decade
    for (int f = 0; f < 4; f++) run(25, 2'(f), 3'd0);
    run(45, 2'd1, 3'd1);
    // R5: sparse enable, ratio 50
    for (int i = 0; i < 200; i++) step(1'b0, (i % 3) != 0, 2'd2, 3'd1);
    // R6: change mid-period and back
    run(37, 2'd3, 3'd1);
    run(12, 2'd2, 3'd0);
    run(25, 2'd3, 3'd1);
    // R7: reset mid-run
    run(7, 2'd1, 3'd1);
    step(1'b1, 1'b1, 2'd1, 3'd1);
    step(1'b1, 1'b1, 2'd1, 3'd1);
    run(25, 2'd1, 3'd1);
    // R4: walk decadeSel 4..7 without restart, ratio 10000
    run(2500, 2'd0, 3'd4);
    run(2500, 2'd0, 3'd5);
    run(2500, 2'd0, 3'd6);
    run(2600, 2'd0, 3'd7);
    // R1: ratio 10000 through three decades, two pulses
    run(20010, 2'd3, 3'd3);
    // random segments
    for (int s = 0; s < 300; s++) begin
      logic [1:0] fs;
      logic [2:0] ds;
      int len;
      fs  = 2'($urandom_range(0, 3));
      ds  = 3'($urandom_range(0, 2));
      len = $urandom_range(1, 120);
      for (int i = 0; i < len; i++)
        step($urandom_range(0, 99) < 2, $urandom_range(0, 99) < 80, fs, ds);
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule